// File: doc/BRIEF.md
# Fetch-Time Co-Issue Detector

This block sits on the instruction-cache refill path of an in-order core that can issue up to three instructions per cycle. A refilled line carries four 32-bit instructions. The block inspects the line once, at refill time, and produces predecode bits that are stored beside it in the cache. The issue stage later reads those bits and does not repeat any hazard analysis. Slot 0 sits in the least significant 32 bits of the line.

The block produces two kinds of bits. For each adjacent pair of slots, a pair bit says that the two instructions may issue together, with the later one in lane 2. For each run of three adjacent slots, a triple bit says that all three may issue together in lanes 1, 2 and 3. Each instruction is classified by the top three bits of its opcode through a fixed flag table inside the block. That table gives the lanes the instruction may occupy, whether it may share a bundle, which of its register fields it reads, and whether it writes a register. The pair and triple results are registered, and a one-cycle ready strobe marks them.

Top module: `coissue_scan`

## Requirements
- R1: While reset is asserted, and after its release until the first refill strobe, every pair bit, every triple bit and the ready strobe are 0.
- R2: For each cycle in which `fill_vld` is high, `pdc_vld` is high in the next cycle and the pair and triple outputs then hold the result for that line. On every other cycle `pdc_vld` is low and the pair and triple outputs keep their last value.
- R3: Instruction field layout: class in bits 31:29, sub-opcode in 28:25 (ignored), Rd in 24:19, Rs in 18:13, Rt in 12:7. Bits 6:0 are ignored. Slot k occupies line bits 32k+31:32k.
- R4: Flag table, by class, giving lane2 / lane3 / pairs / triples / reads-Rd / reads-Rt / writes-Rd:
  - 0 ALU: 1 1 1 1 0 1 1
  - 1 ALU-immediate: 1 1 1 1 0 0 1
  - 2 multiply: 1 0 1 0 0 1 1
  - 3 load: 1 0 1 1 0 0 1
  - 4 store: 1 0 1 1 1 1 0
  - 5 branch: 0 0 1 0 1 1 0
  - 6 float: 1 1 1 1 0 1 1
  - 7 system: all 0
- R5: Pair bit i (slots i, i+1) is 1 exactly when the later slot may occupy lane 2, both slots may share a bundle, and the earlier slot's destination does not hit any source of the later slot.
- R6: A destination hits a source only when the earlier instruction writes Rd, its Rd is nonzero, and that Rd equals one of the following in the later instruction: its Rs (always read), its Rt (only if its class reads Rt), or its Rd (only if its class reads Rd).
- R7: Register 0 as a destination, and a destination from a class that does not write, never blocks co-issue. Two instructions writing the same nonzero Rd is not a hazard.
- R8: Triple bit j (slots j, j+1, j+2) is 1 exactly when pair bits j and j+1 are both 1, all three slots may share a triple bundle, the last slot may occupy lane 3, and slot j's destination does not hit any source of slot j+2.
- R9: A system-class instruction never appears in any pair or triple, and a branch never gets a pair bit as the later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_vld | input | 1 | Refill strobe; the line is valid this cycle |
| fill_line | input | 128 | Refilled line, four instructions, slot 0 in the low bits |
| pair_ok | output | 3 | Bit i: slots i and i+1 may co-issue |
| trip_ok | output | 2 | Bit j: slots j, j+1 and j+2 may co-issue |
| pdc_vld | output | 1 | One-cycle strobe marking fresh pair and triple bits |

## Verification
The properties assume two things about the inputs. First, `fill_vld` is held low while reset is asserted, so the strobe history they look at begins cleanly. Second, `fill_line` only matters in cycles where `fill_vld` is high. The stimulus respects both: it drives inputs only on falling edges, it keeps the strobe low through reset, and it changes the line freely while the strobe is low. Register numbers in the random lines are drawn from a small range so that destination and source collisions, including register 0, occur often. Bursts of back-to-back strobes are mixed with idle gaps so that both the pulse behaviour and the hold behaviour are exercised.

// File: rtl/coissue_scan.sv
module coissue_scan #(
  parameter int SLOTS  = 4,
  parameter int INSN_W = 32,
  parameter int REG_W  = 6,
  parameter int CLS_W  = 3,
  parameter int OPC_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fill_vld,
  input  logic [SLOTS*INSN_W-1:0]   fill_line,
  output logic [SLOTS-2:0]          pair_ok,
  output logic [SLOTS-3:0]          trip_ok,
  output logic                      pdc_vld
);
  localparam int NPAIR  = SLOTS - 1;
  localparam int NTRIP  = SLOTS - 2;
  localparam int CLS_LO = INSN_W - CLS_W;
  localparam int RD_LO  = INSN_W - OPC_W - REG_W;
  localparam int RS_LO  = RD_LO - REG_W;
  localparam int RT_LO  = RS_LO - REG_W;

  typedef struct packed {
    logic ln2, ln3, mate2, mate3, rd_src, rt_src, wr;
  } flags_t;

  function automatic flags_t lookup(input logic [CLS_W-1:0] cls);
    case (cls)
      3'd0:    lookup = 7'b1111011;
      3'd1:    lookup = 7'b1111001;
      3'd2:    lookup = 7'b1010011;
      3'd3:    lookup = 7'b1011001;
      3'd4:    lookup = 7'b1011110;
      3'd5:    lookup = 7'b0010110;
      3'd6:    lookup = 7'b1111011;
      default: lookup = 7'b0000000;
    endcase
  endfunction

  flags_t           fl [SLOTS];
  logic [REG_W-1:0] rd [SLOTS];
  logic [REG_W-1:0] rs [SLOTS];
  logic [REG_W-1:0] rt [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    wire [INSN_W-1:0] ins = fill_line[k*INSN_W +: INSN_W];
    assign fl[k] = lookup(ins[CLS_LO +: CLS_W]);
    assign rd[k] = ins[RD_LO +: REG_W];
    assign rs[k] = ins[RS_LO +: REG_W];
    assign rt[k] = ins[RT_LO +: REG_W];
  end

  function automatic logic hits(input flags_t fe, input logic [REG_W-1:0] de,
                                input flags_t fl_l, input logic [REG_W-1:0] dl,
                                input logic [REG_W-1:0] sl, input logic [REG_W-1:0] tl);
    hits = fe.wr && (de != '0) &&
           ((de == sl) || (fl_l.rt_src && de == tl) || (fl_l.rd_src && de == dl));
  endfunction

  logic [NPAIR-1:0] pair_c;
  logic [NTRIP-1:0] trip_c;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign pair_c[i] = fl[i+1].ln2 && fl[i].mate2 && fl[i+1].mate2 &&
                       !hits(fl[i], rd[i], fl[i+1], rd[i+1], rs[i+1], rt[i+1]);
  end

  for (genvar j = 0; j < NTRIP; j++) begin : g_trip
    assign trip_c[j] = pair_c[j] && pair_c[j+1] &&
                       fl[j].mate3 && fl[j+1].mate3 && fl[j+2].mate3 &&
                       fl[j+2].ln3 &&
                       !hits(fl[j], rd[j], fl[j+2], rd[j+2], rs[j+2], rt[j+2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_ok <= '0;
      trip_ok <= '0;
      pdc_vld <= 1'b0;
    end else begin
      pdc_vld <= fill_vld;
      if (fill_vld) begin
        pair_ok <= pair_c;
        trip_ok <= trip_c;
      end
    end
  end

  AST_READY_FOLLOWS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld |=> pdc_vld); // R2
  AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_vld |=> !pdc_vld); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_vld |=> ($stable(pair_ok) && $stable(trip_ok))); // R2
  AST_TRIP_NEEDS_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ok[0] |-> (pair_ok[0] && pair_ok[1])); // R8
  AST_SYS_SLOT0_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && fill_line[INSN_W-1 -: CLS_W] == 3'd7) |=> (!pair_ok[0] && !trip_ok[0])); // R9
  AST_BRANCH_NOT_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && fill_line[2*INSN_W-1 -: CLS_W] == 3'd5) |=> !pair_ok[0]); // R9
endmodule

// File: tb/coissue_scan_tb.sv
module coissue_scan_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fill_vld = 1'b0;
  logic [127:0] fill_line = '0;
  logic [2:0]   pair_ok;
  logic [1:0]   trip_ok;
  logic         pdc_vld;

  coissue_scan dut_i (
    .clk(clk), .rst_n(rst_n), .fill_vld(fill_vld), .fill_line(fill_line),
    .pair_ok(pair_ok), .trip_ok(trip_ok), .pdc_vld(pdc_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;
  logic [4:0]  exp_q [$];
  string       tag_q [$];
  logic [4:0]  last_exp = '0;

  // flags: {lane2, lane3, pairs, triples, reads_rd, reads_rt, writes_rd}
  function automatic logic [6:0] cls_flags(input logic [2:0] c);
    case (c)
      3'd0: return 7'b1111011;
      3'd1: return 7'b1111001;
      3'd2: return 7'b1010011;
      3'd3: return 7'b1011001;
      3'd4: return 7'b1011110;
      3'd5: return 7'b0010110;
      3'd6: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int c, input int rdv, input int rsv, input int rtv);
    logic [31:0] w;
    w = '0;
    w[31:29] = c[2:0];
    w[28:25] = 4'hA;
    w[24:19] = rdv[5:0];
    w[18:13] = rsv[5:0];
    w[12:7]  = rtv[5:0];
    w[6:0]   = 7'h55;
    return w;
  endfunction

  function automatic bit blocks(input logic [31:0] e, input logic [31:0] l);
    logic [6:0] fe, fl;
    fe = cls_flags(e[31:29]);
    fl = cls_flags(l[31:29]);
    if (!fe[0] || e[24:19] == 6'd0) return 1'b0;
    if (e[24:19] == l[18:13]) return 1'b1;
    if (fl[1] && e[24:19] == l[12:7]) return 1'b1;
    if (fl[2] && e[24:19] == l[24:19]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [4:0] model(input logic [127:0] ln);
    logic [31:0] s [4];
    logic [6:0]  f [4];
    logic [2:0]  p;
    logic [1:0]  t;
    for (int k = 0; k < 4; k++) begin
      s[k] = ln[32*k +: 32];
      f[k] = cls_flags(s[k][31:29]);
    end
    for (int i = 0; i < 3; i++)
      p[i] = f[i+1][6] && f[i][4] && f[i+1][4] && !blocks(s[i], s[i+1]);
    for (int j = 0; j < 2; j++)
      t[j] = p[j] && p[j+1] && f[j][3] && f[j+1][3] && f[j+2][3] &&
             f[j+2][5] && !blocks(s[j], s[j+2]);
    return {t, p};
  endfunction

  task automatic send(input logic [31:0] s0, input logic [31:0] s1,
                      input logic [31:0] s2, input logic [31:0] s3, input string tag);
    @(negedge clk);
    fill_line = {s3, s2, s1, s0};
    fill_vld  = 1'b1;
    exp_q.push_back(model(fill_line));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      fill_vld  = 1'b0;
      fill_line = {4{32'hDEAD_BEEF}};
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pdc_vld) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2 ready without strobe: actual pdc_vld=1 expected 0");
        end else begin
          logic [4:0] e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          last_exp = e;
          if ({trip_ok, pair_ok} !== e) begin
            fails++;
            $display("FAIL %s: actual trip=%b pair=%b expected trip=%b pair=%b",
                     tg, trip_ok, pair_ok, e[4:3], e[2:0]);
          end
        end
      end
    end
  end

  task automatic check_hold(input string tag);
    @(negedge clk);
    checks++;
    if (pdc_vld !== 1'b0 || {trip_ok, pair_ok} !== last_exp) begin
      fails++;
      $display("FAIL %s hold: actual vld=%b out=%b expected vld=0 out=%b",
               tag, pdc_vld, {trip_ok, pair_ok}, last_exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({trip_ok, pair_ok, pdc_vld} !== 6'b0) begin
      fails++;
      $display("FAIL R1 in reset: actual %b expected 000000", {trip_ok, pair_ok, pdc_vld});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if ({trip_ok, pair_ok, pdc_vld} !== 6'b0) begin
      fails++;
      $display("FAIL R1 after reset: actual %b expected 000000", {trip_ok, pair_ok, pdc_vld});
    end

    // R5 R8 R3: independent ALU ops, all bundles allowed
    send(mk(0,1,10,11), mk(0,2,12,13), mk(6,3,14,15), mk(1,4,16,17), "R5_R8_indep");
    idle(2);
    check_hold("R2");
    // R6: destination feeds Rs of next
    send(mk(0,5,10,11), mk(0,6,5,12), mk(0,7,13,14), mk(0,8,15,16), "R6_rs_hit");
    // R6: Rt not read by ALU-immediate, read by ALU
    send(mk(0,5,10,11), mk(1,6,12,5), mk(0,7,13,6), mk(0,8,15,16), "R6_rt_sel");
    // R6 R7: store reads Rd; ALU same Rd is only a write-write
    send(mk(0,5,10,11), mk(4,5,12,13), mk(0,5,14,15), mk(0,5,16,17), "R6_rd_src");
    // R7: register 0 destination, non-writing store destination
    send(mk(0,0,10,11), mk(0,9,0,0), mk(4,9,20,21), mk(0,3,9,9), "R7_r0_nowr");
    idle(1);
    // R9: branch as later slot, system in slot 2
    send(mk(0,1,10,11), mk(5,2,12,13), mk(7,3,14,15), mk(0,4,16,17), "R9_br_sys");
    // R4 R8: multiply in lane 3 and in slot 0
    send(mk(2,1,10,11), mk(0,2,12,13), mk(2,3,14,15), mk(3,4,16,17), "R4_R8_lanes");
    // R8: slot0 destination hits slot2 source only
    send(mk(0,5,10,11), mk(0,6,12,13), mk(0,7,5,14), mk(0,8,15,16), "R8_far_hit");
    // R3: sub-opcode and low bits ignored
    send(mk(0,1,10,11) ^ 32'h1E00_007F, mk(0,2,12,13) ^ 32'h0600_0011,
         mk(0,3,14,15), mk(0,4,16,17), "R3_fields");
    idle(3);
    check_hold("R2");

    // random bursts with small register range
    for (int b = 0; b < 60; b++) begin
      int len;
      len = 1 + ($urandom % 5);
      for (int n = 0; n < len; n++) begin
        logic [31:0] w [4];
        for (int k = 0; k < 4; k++)
          w[k] = mk($urandom % 8, $urandom % 4, $urandom % 4, $urandom % 4) ^ {3'b0, 4'($urandom), 18'b0, 7'($urandom)};
        send(w[0], w[1], w[2], w[3], "R4_R5_R6_R8_rand");
      end
      idle(1 + ($urandom % 3));
    end
    idle(2);
    check_hold("R2");
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing ready: actual pending=%0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule